// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a clocked host port and an external asynchronous static RAM of 128K x 8. It takes one single-beat read or write at a time over a valid/ready handshake. It turns each request into select, write-strobe and output-enable sequences whose lengths come from the memory's minimum timings in nanoseconds and the clock period. The memory has one active-low select and one active-high select. The memory sees a write only while both selects are active and the write strobe is low.

Between accesses the controller leaves the memory in standby: both selects inactive, output enable high, data bus released. After reset it waits one operation-recovery time before it accepts the first request. The data bus is split into an output value, an output enable and an input value, so the pad tristate stays outside the block. A read captures the memory's data on the edge that closes the access window and returns it with a one-cycle valid pulse.

Top module: `sram_ctrl`

## Requirements
- R1: While rst_ni is low, mem_cs_n_o=1, mem_cs_o=0, mem_we_n_o=1, mem_oe_n_o=1, mem_dq_oe_o=0, req_ready_o=0 and rsp_valid_o=0, and an assertion of rst_ni during an access forces these values at once.
- R2: After reset is released, req_ready_o stays low for 4 clock edges (the recovery time at the default timing) and rises after the 4th edge. A request presented during that wait starts no memory cycle.
- R3: Whenever req_ready_o is high, the memory is in standby: both selects inactive, OE high, WE high and the data bus not driven.
- R4: A read accepted at an edge selects the memory with OE low and WE high for the next 4 cycles. It samples mem_dq_i at the edge that ends the 4th cycle, and in the following cycle it raises rsp_valid_o for exactly one cycle with that byte on rsp_rdata_o, with req_ready_o high in that same cycle.
- R5: A write selects the memory for 4 cycles with OE high throughout. WE is low for the first 3 of them and high in the 4th, and the address and write data are presented from the first WE-low cycle.
- R6: mem_dq_oe_o is high exactly for the WE-low cycles plus one hold cycle, and never while OE is low.
- R7: A write whose preceding completed access was a read is preceded by one deselected cycle with OE high, so it is selected from the 2nd cycle after acceptance and ready returns one cycle later. A write after a write has no such gap.
- R8: mem_addr_o equals the accepted address in every selected cycle and does not change while the memory stays selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Host request valid |
| req_ready_o | output | 1 | Controller can accept a request |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 17 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data valid pulse |
| rsp_rdata_o | output | 8 | Read data |
| mem_addr_o | output | 17 | Memory address |
| mem_cs_n_o | output | 1 | Memory select, active low |
| mem_cs_o | output | 1 | Memory select, active high |
| mem_we_n_o | output | 1 | Memory write strobe, active low |
| mem_oe_n_o | output | 1 | Memory output enable, active low |
| mem_dq_o | output | 8 | Data driven to memory |
| mem_dq_oe_o | output | 1 | Enable for the data drivers |
| mem_dq_i | input | 8 | Data from memory |

## Verification
The hardest case to reach is the read-to-write turnaround. The gap is inserted only when the last completed access was a read, so the stimulus table mixes reads and writes in orders that give both read-then-write and write-then-write pairs. Every pair's select start and ready return are measured. A second hard case is a reset arriving in the middle of a write, with WE still low. A directed test drops rst_ni between clock edges during the pulse and checks that all strobes go inactive at once and that the recovery wait starts again.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_PWRUP, ST_IDLE, ST_TURN, ST_READ, ST_WRITE
  } state_e;

  // ceiling(ns / clock period), clock period in ps
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned PWR_LEN  = 4,
  parameter int unsigned RD_LEN   = 4,
  parameter int unsigned WR_LEN   = 4,
  parameter int unsigned TURN_LEN = 1,
  parameter int unsigned CNT_W    = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_we_i,
  output state_e           state_q_o,
  output state_e           state_d_o,
  output logic [CNT_W-1:0] cnt_q_o,
  output logic [CNT_W-1:0] cnt_d_o
);
  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_rd_q, last_rd_d;

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q + 1'b1;
    last_rd_d = last_rd_q;
    unique case (state_q)
      ST_PWRUP: if (cnt_q == CNT_W'(PWR_LEN - 1)) begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (req_valid_i) begin
          if (!req_we_i)      state_d = ST_READ;
          else if (last_rd_q) state_d = ST_TURN;
          else                state_d = ST_WRITE;
        end
      end
      ST_TURN: if (cnt_q == CNT_W'(TURN_LEN - 1)) begin
        state_d = ST_WRITE;
        cnt_d   = '0;
      end
      ST_READ: if (cnt_q == CNT_W'(RD_LEN - 1)) begin
        state_d   = ST_IDLE;
        cnt_d     = '0;
        last_rd_d = 1'b1;
      end
      ST_WRITE: if (cnt_q == CNT_W'(WR_LEN - 1)) begin
        state_d   = ST_IDLE;
        cnt_d     = '0;
        last_rd_d = 1'b0;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_PWRUP;
      cnt_q     <= '0;
      last_rd_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      cnt_q     <= cnt_d;
      last_rd_q <= last_rd_d;
    end
  end

  assign state_q_o = state_q;
  assign state_d_o = state_d;
  assign cnt_q_o   = cnt_q;
  assign cnt_d_o   = cnt_d;
endmodule

// File: rtl/sram_ctrl_strobe.sv
module sram_ctrl_strobe
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned WP_LEN = 3,
  parameter int unsigned CNT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  state_e           state_d_i,
  input  logic [CNT_W-1:0] cnt_d_i,
  output logic             cs_n_o,
  output logic             cs_o,
  output logic             we_n_o,
  output logic             oe_n_o,
  output logic             dq_oe_o
);
  logic sel_d, rd_d, wr_d;

  assign sel_d = (state_d_i == ST_READ) || (state_d_i == ST_WRITE);
  assign rd_d  = (state_d_i == ST_READ);
  assign wr_d  = (state_d_i == ST_WRITE);

  // strobes come straight from flops, decoded from next state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_n_o  <= 1'b1;
      cs_o    <= 1'b0;
      we_n_o  <= 1'b1;
      oe_n_o  <= 1'b1;
      dq_oe_o <= 1'b0;
    end else begin
      cs_n_o  <= !sel_d;
      cs_o    <= sel_d;
      oe_n_o  <= !rd_d;
      we_n_o  <= !(wr_d && (cnt_d_i < CNT_W'(WP_LEN)));
      dq_oe_o <= wr_d && (cnt_d_i <= CNT_W'(WP_LEN));
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 17,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CLK_PS    = 10000,
  parameter int unsigned T_RC_NS   = 40,
  parameter int unsigned T_WC_NS   = 35,
  parameter int unsigned T_WP_NS   = 30,
  parameter int unsigned T_DS_NS   = 20,
  parameter int unsigned T_REC_NS  = 40,
  parameter int unsigned TURN_CYC  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_cs_n_o,
  output logic              mem_cs_o,
  output logic              mem_we_n_o,
  output logic              mem_oe_n_o,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe_o,
  input  logic [DATA_W-1:0] mem_dq_i
);
  localparam int unsigned RD_LEN   = max2(ns2cyc(T_RC_NS, CLK_PS), 1);
  localparam int unsigned WP_LEN   = max2(max2(ns2cyc(T_WP_NS, CLK_PS),
                                               ns2cyc(T_DS_NS, CLK_PS)), 1);
  localparam int unsigned WR_LEN   = max2(ns2cyc(T_WC_NS, CLK_PS), WP_LEN + 1);
  localparam int unsigned PWR_LEN  = max2(ns2cyc(T_REC_NS, CLK_PS), 1);
  localparam int unsigned TURN_LEN = max2(TURN_CYC, 1);
  localparam int unsigned MAX_LEN  = max2(max2(RD_LEN, WR_LEN), max2(PWR_LEN, TURN_LEN));
  localparam int unsigned CNT_W    = $clog2(MAX_LEN + 1);

  state_e           state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             accept, capture;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rsp_q;

  sram_ctrl_seq #(
    .PWR_LEN (PWR_LEN),
    .RD_LEN  (RD_LEN),
    .WR_LEN  (WR_LEN),
    .TURN_LEN(TURN_LEN),
    .CNT_W   (CNT_W)
  ) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .req_we_i   (req_we_i),
    .state_q_o  (state_q),
    .state_d_o  (state_d),
    .cnt_q_o    (cnt_q),
    .cnt_d_o    (cnt_d)
  );

  sram_ctrl_strobe #(
    .WP_LEN(WP_LEN),
    .CNT_W (CNT_W)
  ) i_strobe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .state_d_i(state_d),
    .cnt_d_i  (cnt_d),
    .cs_n_o   (mem_cs_n_o),
    .cs_o     (mem_cs_o),
    .we_n_o   (mem_we_n_o),
    .oe_n_o   (mem_oe_n_o),
    .dq_oe_o  (mem_dq_oe_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_ready_o && req_valid_i;
  assign capture     = (state_q == ST_READ) && (cnt_q == CNT_W'(RD_LEN - 1));

  // address and data held after the access ends (hold time)
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      rsp_q   <= 1'b0;
    end else begin
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      if (capture) rdata_q <= mem_dq_i;
      rsp_q <= capture;
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_dq_o    = wdata_q;
  assign rsp_valid_o = rsp_q;
  assign rsp_rdata_o = rdata_q;
endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 17,
  parameter int unsigned CLK_PS   = 10000,
  parameter int unsigned T_WP_NS  = 30,
  parameter int unsigned T_DS_NS  = 20,
  parameter int unsigned T_REC_NS = 40
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_cs_n_o,
  input logic              mem_cs_o,
  input logic              mem_we_n_o,
  input logic              mem_oe_n_o,
  input logic              mem_dq_oe_o
);
  localparam int unsigned WP_LEN  = max2(max2(ns2cyc(T_WP_NS, CLK_PS),
                                              ns2cyc(T_DS_NS, CLK_PS)), 1);
  localparam int unsigned PWR_LEN = max2(ns2cyc(T_REC_NS, CLK_PS), 1);

  int unsigned since_rst, lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_rst <= 0;
      lo_cnt    <= 0;
    end else begin
      if (since_rst < PWR_LEN) since_rst <= since_rst + 1;
      lo_cnt <= mem_we_n_o ? 0 : lo_cnt + 1;
    end
  end

  assert_pwrup_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_rst < PWR_LEN) |-> (!req_ready_o && mem_cs_n_o));

  assert_idle_standby_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (mem_cs_n_o && !mem_cs_o && mem_oe_n_o && mem_we_n_o && !mem_dq_oe_o));

  assert_read_strobes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_we_n_o));

  assert_rsp_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_we_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (lo_cnt == WP_LEN));

  assert_we_sel_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_n_o |-> (!mem_cs_n_o && mem_cs_o && mem_oe_n_o && mem_dq_oe_o));

  assert_no_contention_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_n_o);

  assert_hold_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_n_o) |-> (mem_dq_oe_o && !mem_cs_n_o));

  assert_oe_gap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!mem_oe_n_o) |-> !mem_dq_oe_o);

  assert_addr_stable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_cs_n_o && $past(!mem_cs_n_o)) |-> $stable(mem_addr_o));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W  (ADDR_W),
  .CLK_PS  (CLK_PS),
  .T_WP_NS (T_WP_NS),
  .T_DS_NS (T_DS_NS),
  .T_REC_NS(T_REC_NS)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o),
  .mem_addr_o (mem_addr_o),
  .mem_cs_n_o (mem_cs_n_o),
  .mem_cs_o   (mem_cs_o),
  .mem_we_n_o (mem_we_n_o),
  .mem_oe_n_o (mem_oe_n_o),
  .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_o, mem_dq_i;

  int total = 0;
  int bad   = 0;
  bit last_rd = 1'b0;

  logic [7:0] model [256];
  logic       prev_we_n = 1'b1;
  logic [16:0] pend_addr;
  logic [7:0]  pend_data;

  always #2 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .mem_addr_o(mem_addr), .mem_cs_n_o(mem_cs_n), .mem_cs_o(mem_cs),
    .mem_we_n_o(mem_we_n), .mem_oe_n_o(mem_oe_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe_o(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model: reads when selected with OE low, writes at WE rising
  assign mem_dq_i = (!mem_cs_n && mem_cs && !mem_oe_n && mem_we_n) ? model[mem_addr[7:0]] : 8'h5A;

  always @(negedge clk) begin
    if (!mem_we_n) begin
      pend_addr = mem_addr;
      pend_data = mem_dq_o;
    end else if (!prev_we_n) begin
      model[pend_addr[7:0]] = pend_data;
    end
    prev_we_n = mem_we_n;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_standby(input string req);
    chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe, req, "standby strobes",
        {mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
  endtask

  typedef struct packed {
    logic        we;
    logic [16:0] addr;
    logic [7:0]  data;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 17'h00012, 8'hA5},
    '{1'b0, 17'h00012, 8'hA5},
    '{1'b1, 17'h1FF34, 8'h3C},
    '{1'b1, 17'h00056, 8'hC3},
    '{1'b0, 17'h1FF34, 8'h3C},
    '{1'b0, 17'h00056, 8'hC3},
    '{1'b1, 17'h0AB78, 8'h0F},
    '{1'b0, 17'h0AB78, 8'h0F},
    '{1'b0, 17'h00012, 8'hA5}
  };

  task automatic run_op(input logic we, input logic [16:0] addr, input logic [7:0] data);
    int k, sel_n, first_sel, we_lo, oe_lo, dq_n, rsp_n, turn;
    bit addr_ok, data_ok;
    while (!req_ready) @(negedge clk);
    turn = (we && last_rd) ? 1 : 0;
    req_valid = 1'b1; req_we = we; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    k = 1; sel_n = 0; first_sel = 0; we_lo = 0; oe_lo = 0; dq_n = 0; rsp_n = 0;
    addr_ok = 1'b1; data_ok = 1'b1;
    while (!req_ready && k < 40) begin
      if (!mem_cs_n && mem_cs) begin
        sel_n++;
        if (first_sel == 0) first_sel = k;
        if (mem_addr != addr) addr_ok = 1'b0;
      end
      if (!mem_we_n) begin
        we_lo++;
        if (mem_dq_o != data) data_ok = 1'b0;
      end
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) dq_n++;
      if (rsp_valid) rsp_n++;
      k++;
      @(negedge clk);
    end
    chk(k == 5 + turn, "R7", "ready return cycle", k, 5 + turn);
    chk(first_sel == 1 + turn, "R7", "first select cycle", first_sel, 1 + turn);
    chk(sel_n == 4, we ? "R5" : "R4", "select cycles", sel_n, 4);
    chk(addr_ok, "R8", "address while selected", mem_addr, addr);
    chk(rsp_n == 0, "R4", "early response", rsp_n, 0);
    if (we) begin
      chk(we_lo == 3, "R5", "WE low cycles", we_lo, 3);
      chk(oe_lo == 0, "R5", "OE low during write", oe_lo, 0);
      chk(data_ok, "R5", "write data", mem_dq_o, data);
      chk(dq_n == 4, "R6", "bus drive cycles", dq_n, 4);
      chk(!rsp_valid, "R4", "response on write", rsp_valid, 0);
    end else begin
      chk(oe_lo == 4, "R4", "OE low cycles", oe_lo, 4);
      chk(we_lo == 0 && dq_n == 0, "R6", "bus driven on read", dq_n, 0);
      chk(rsp_valid, "R4", "response valid", rsp_valid, 1);
      chk(rsp_rdata == data, "R4", "read data", rsp_rdata, data);
    end
    chk_standby("R3");
    last_rd = !we;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk_standby("R1");
    chk(!req_ready && !rsp_valid, "R1", "ready/rsp in reset", {req_ready, rsp_valid}, 0);

    // R2: recovery wait, request during wait ignored
    rst_n = 1'b1;
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h000FF; req_wdata = 8'h99;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      if (i == 3) req_valid = 1'b0;
      chk(req_ready == (i >= 4), "R2", "ready during recovery", req_ready, i >= 4);
      chk(mem_cs_n && mem_we_n, "R2", "no strobe during recovery", mem_we_n, 1);
    end

    for (int v = 0; v < NV; v++) run_op(VEC[v].we, VEC[v].addr, VEC[v].data);

    // write after write (no gap) and read of unseen byte
    run_op(1'b1, 17'h0009A, 8'h11);
    run_op(1'b1, 17'h0019B, 8'h22);
    run_op(1'b0, 17'h0009A, 8'h11);

    // R1: reset in the middle of a write pulse
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 17'h000C0; req_wdata = 8'h44;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(!mem_we_n, "R5", "WE low before reset", mem_we_n, 0);
    rst_n = 1'b0;
    #1;
    chk_standby("R1");
    chk(!req_ready, "R1", "ready in reset", req_ready, 0);
    @(negedge clk);
    rst_n = 1'b1;
    last_rd = 1'b0;
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk(req_ready == (i >= 4), "R2", "ready after mid-access reset", req_ready, i >= 4);
    end
    run_op(1'b0, 17'h1FF34, 8'h3C);
    run_op(1'b1, 17'h000D1, 8'h5E);
    run_op(1'b0, 17'h000D1, 8'h5E);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule